// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sequences a successive-approximation converter inside a small peripheral. Software reaches it through a register port: a control register with enable, start, completion flag, interrupt enable and clock divider, and a selection register with reference, result alignment and input channel. A third register returns the latest result. The analog comparator and its DAC are replaced by a 10-bit digital sample input. The block captures this input at a fixed ADC clock inside each conversion.

The ADC clock is made from the system clock by a programmable divider. A normal conversion lasts 13 ADC clocks. The first conversion started after the block is enabled lasts 25, because it performs initialisation. The selected channel and reference drive the analog multiplexer through two outputs. A change to them written while a conversion runs waits until that conversion ends. The alignment of the result changes the moment it is written.

Top module: `adc_seq`

## Requirements
- R1: The ADC clock divider is control bits [2:0]: codes 0 and 1 divide the system clock by 2, and codes 2..7 divide by 4, 8, 16, 32, 64, 128. A normal conversion holds `busy` high for exactly 13 × divider system cycles, counted from the clock edge that takes the start write.
- R2: The first conversion started after enable rises lasts 25 × divider system cycles. This includes a single write that sets enable (control bit 7) and start (control bit 6) together.
- R3: Control bit 6 reads as one exactly while a conversion runs and clears itself at completion. Writing zero to it, even mid-conversion, neither aborts nor starts anything. Control reads as {enable, busy, 0, flag, irq enable, divider} in bits [7:0].
- R4: Writing enable to zero during a conversion ends it on that edge. The result register keeps its old value and the completion flag is not set.
- R5: Selection-register writes (reference in bits [7:6], channel in bits [2:0]) take effect at once when idle. During a conversion they are held and applied on the edge where the conversion completes, or on the abort edge. `chan_sel`, `ref_sel` and the selection read-back show the applied values.
- R6: Selection bit 5 sets left alignment and takes effect immediately, also mid-conversion. When it is set, the data register (address 2) reads {result, 6'b0}; when it is clear, it reads {6'b0, result}.
- R7: Reference code 2'b10 is reserved. A write carrying it leaves the reference unchanged. Codes 00, 01 and 11 select the external pin, the supply and the internal 1.1 V source.
- R8: The completion flag (control bit 4) sets on the completion edge and clears when a one is written to bit 4. When both happen on the same edge, the set wins.
- R9: `irq` is high exactly when the completion flag and the interrupt enable (control bit 3) are both one.
- R10: `sample_in` is captured on the 2nd ADC clock of a normal conversion and on the 14th of a first conversion. The data register changes only on a completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 selection, 2 data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| sample_in | input | 10 | Digitised converter value |
| chan_sel | output | 3 | Applied input channel |
| ref_sel | output | 2 | Applied reference code |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Completion interrupt request |

## Verification
`busy` rises on the edge that takes the start write and falls exactly 13 or 25 × divider cycles later. The flag, result, deferred selection and `irq` all change on that falling edge. An abort takes effect on the edge of the disabling write. Read data is combinational, so alignment changes are visible in the cycle after the write edge. The bench keeps a behavioural model that counts elapsed system cycles since start and updates on the same edges. It compares every output on each falling clock edge. Directed checks also count the cycles `busy` stays high against the product given in R1 and R2.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int RES_W        = 10,
  parameter int DATA_W       = 16,
  parameter int CH_W         = 3,
  parameter int NORM_LEN     = 13,
  parameter int FIRST_LEN    = 25,
  parameter int NORM_SAMPLE  = 2,
  parameter int FIRST_SAMPLE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [RES_W-1:0]  sample_in,
  output logic [CH_W-1:0]   chan_sel,
  output logic [1:0]        ref_sel,
  output logic              busy,
  output logic              irq
);
  localparam int CNT_W = $clog2(FIRST_LEN + 1);
  localparam int PAD   = DATA_W - RES_W;

  logic             en, done, ie, left, first, long_c;
  logic [2:0]       ps;
  logic [6:0]       pcnt;
  logic [CNT_W-1:0] tcnt;
  logic [RES_W-1:0] samp, res;
  logic [1:0]       ref_req;
  logic [CH_W-1:0]  ch_req;

  wire wr_ctrl = reg_we && (reg_addr == 2'd0);
  wire wr_sel  = reg_we && (reg_addr == 2'd1);

  wire [7:0] div = (ps < 3'd2) ? 8'd2 : (8'd1 << ps);
  wire tick      = en && ({1'b0, pcnt} == div - 8'd1);

  wire [CNT_W-1:0] tnext   = tcnt + 1'b1;
  wire [CNT_W-1:0] len     = long_c ? CNT_W'(FIRST_LEN) : CNT_W'(NORM_LEN);
  wire [CNT_W-1:0] spoint  = long_c ? CNT_W'(FIRST_SAMPLE) : CNT_W'(NORM_SAMPLE);

  wire abort   = busy && wr_ctrl && !reg_wdata[7];
  wire finish  = busy && tick && !abort && (tnext == len);
  wire capture = busy && tick && (tnext == spoint);
  wire start   = wr_ctrl && reg_wdata[7] && reg_wdata[6] && !busy;

  wire [1:0]      new_ref  = (reg_wdata[7:6] == 2'b10) ? ref_req : reg_wdata[7:6];
  wire [CH_W-1:0] new_ch   = reg_wdata[CH_W-1:0];
  wire            sel_open = !busy || finish || abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; ps <= '0; ie <= 1'b0; done <= 1'b0; busy <= 1'b0;
      first <= 1'b0; long_c <= 1'b0; pcnt <= '0; tcnt <= '0;
      samp <= '0; res <= '0; left <= 1'b0;
      ref_req <= '0; ch_req <= '0; ref_sel <= '0; chan_sel <= '0;
    end else begin
      if (wr_ctrl) begin
        en <= reg_wdata[7];
        ie <= reg_wdata[3];
        ps <= reg_wdata[2:0];
      end

      if (start || !en || tick) pcnt <= '0;
      else                      pcnt <= pcnt + 7'd1;

      if (start)                                    first <= 1'b0;
      else if (wr_ctrl && reg_wdata[7] && !en)      first <= 1'b1;

      if (start) begin
        busy   <= 1'b1;
        long_c <= first || !en;
        tcnt   <= '0;
      end else begin
        if (finish || abort) busy <= 1'b0;
        if (busy && tick)    tcnt <= tnext;
      end

      if (capture) samp <= sample_in;
      if (finish)  res  <= samp;

      if (finish)                         done <= 1'b1;
      else if (wr_ctrl && reg_wdata[4])   done <= 1'b0;

      if (wr_sel) begin
        left    <= reg_wdata[5];
        ref_req <= new_ref;
        ch_req  <= new_ch;
      end
      if (sel_open) begin
        ref_sel  <= wr_sel ? new_ref : ref_req;
        chan_sel <= wr_sel ? new_ch  : ch_req;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DATA_W'({en, busy, 1'b0, done, ie, ps});
      2'd1:    reg_rdata = DATA_W'({ref_sel, left, {(5-CH_W){1'b0}}, chan_sel});
      2'd2:    reg_rdata = left ? {res, {PAD{1'b0}}} : {{PAD{1'b0}}, res};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = done && ie;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             en,
  input logic             done,
  input logic [CH_W-1:0]  chan_sel,
  input logic [1:0]       ref_sel,
  input logic [RES_W-1:0] res,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [7:0]       reg_wdata
);
  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(chan_sel) && $stable(ref_sel)));

  // R7
  ref_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_sel != 2'b10);

  // R4
  abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (!busy && !$rose(done) && $stable(res)));

  // R3
  no_self_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(reg_we && reg_addr == 2'd0 && reg_wdata[7] && reg_wdata[6])) |=> !busy);

  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R10
  result_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res) |-> $fell(busy));
endmodule

bind adc_seq adc_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .en(en), .done(done),
  .chan_sel(chan_sel), .ref_sel(ref_sel), .res(res),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/adc_seq_test.sv
module adc_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] reg_wdata = '0;
  logic [9:0] sample_in = '0;
  logic [15:0] reg_rdata;
  logic [2:0] chan_sel;
  logic [1:0] ref_sel;
  logic busy, irq;

  int errs = 0, checks = 0, cyc = 0;
  bit ended = 0;

  adc_seq uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
               .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_in(sample_in),
               .chan_sel(chan_sel), .ref_sel(ref_sel), .busy(busy), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    sample_in <= 10'((cyc * 37 + 11) % 1024);
  end

  // behavioural reference model: elapsed-cycle counting per conversion
  int m_en, m_busy, m_done, m_ie, m_left, m_first, m_long, m_ps, m_e;
  int m_samp, m_res, m_refq, m_refa, m_chq, m_cha;
  int dv, nref;
  bit wc, ws, ab, fin, st;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_done = 0; m_ie = 0; m_left = 0; m_first = 0;
      m_long = 0; m_ps = 0; m_e = 0; m_samp = 0; m_res = 0;
      m_refq = 0; m_refa = 0; m_chq = 0; m_cha = 0;
    end else begin
      dv = (m_ps < 2) ? 2 : (1 << m_ps);
      wc = reg_we && reg_addr == 2'd0;
      ws = reg_we && reg_addr == 2'd1;
      ab = m_busy && wc && !reg_wdata[7];
      fin = 0;
      if (m_busy && !ab) begin
        m_e++;
        if (m_e == (m_long ? 14 : 2) * dv) m_samp = sample_in;
        if (m_e == (m_long ? 25 : 13) * dv) fin = 1;
      end
      st = wc && reg_wdata[7] && reg_wdata[6] && !m_busy;
      nref = (reg_wdata[7:6] == 2'b10) ? m_refq : int'(reg_wdata[7:6]);
      if (!m_busy || fin || ab) begin
        m_refa = ws ? nref : m_refq;
        m_cha  = ws ? int'(reg_wdata[2:0]) : m_chq;
      end
      if (ws) begin m_refq = nref; m_chq = reg_wdata[2:0]; m_left = reg_wdata[5]; end
      if (fin) begin m_res = m_samp; m_done = 1; m_busy = 0; end
      else if (wc && reg_wdata[4]) m_done = 0;
      if (ab) m_busy = 0;
      if (st) begin m_long = m_first || !m_en; m_first = 0; m_busy = 1; m_e = 0; end
      else if (wc && reg_wdata[7] && !m_en) m_first = 1;
      if (wc) begin m_en = reg_wdata[7]; m_ie = reg_wdata[3]; m_ps = reg_wdata[2:0]; end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(int a);
    case (a)
      0: return (m_en << 7) | (m_busy << 6) | (m_done << 4) | (m_ie << 3) | m_ps;
      1: return (m_refa << 6) | (m_left << 5) | m_cha;
      2: return m_left ? (m_res << 6) : m_res;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) if (rst_n && !ended) begin
    check(busy == m_busy[0], "R3 busy vs model", busy, m_busy);
    check(irq == (m_done[0] && m_ie[0]), "R9 irq vs model", irq, m_done & m_ie);
    check(chan_sel == 3'(m_cha) && ref_sel == 2'(m_refa), "R5 selection vs model",
          {ref_sel, chan_sel}, (m_refa << 3) | m_cha);
    check(reg_rdata == 16'(exp_rd(reg_addr)), "R10 read data vs model", reg_rdata, exp_rd(reg_addr));
  end

  function automatic logic [7:0] ctl(bit e, bit s, bit c, bit i, int p);
    return {e, s, 1'b0, c, i, 3'(p)};
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1 v = reg_rdata; reg_addr = 2'd2;
  endtask

  task automatic run(logic [7:0] d, int exp_len, string tag);
    int n = 0;
    wr(2'd0, d);
    while (busy) begin n++; @(negedge clk); end
    check(n == exp_len, tag, n, exp_len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1; errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(2'd0, v);
    check(v == 16'h0 && !busy && !irq, "R3 reset state", v, 0);

    wr(2'd1, 8'b01_0_00_101);
    check(chan_sel == 3'd5 && ref_sel == 2'd1, "R5 idle write immediate", {ref_sel, chan_sel}, 8'o15);

    run(ctl(1, 1, 0, 1, 0), 50, "R2 first conversion with enable+start");
    check(irq == 1'b1, "R9 irq after completion", irq, 1);
    peek(2'd0, v);
    check(v[4] == 1'b1 && v[6] == 1'b0, "R8 flag set, start cleared", v, 16'h98);

    wr(2'd0, ctl(1, 0, 1, 1, 0));
    check(irq == 1'b0, "R8 write-one clears flag", irq, 0);

    run(ctl(1, 1, 0, 1, 1), 26, "R1 divider code 1");

    wr(2'd0, ctl(1, 1, 1, 1, 2));
    repeat (4) @(negedge clk);
    wr(2'd1, 8'b11_1_00_010);
    check(chan_sel == 3'd5 && ref_sel == 2'd1, "R5 held during conversion", {ref_sel, chan_sel}, 8'o15);
    peek(2'd2, v);
    check(v[5:0] == 6'd0, "R6 left alignment immediate", v[5:0], 0);
    wr(2'd0, ctl(1, 0, 0, 1, 2));
    check(busy == 1'b1, "R3 writing start zero keeps conversion", busy, 1);
    while (busy) @(negedge clk);
    check(chan_sel == 3'd2 && ref_sel == 2'd3, "R5 applied at completion", {ref_sel, chan_sel}, 8'o32);

    run(ctl(1, 1, 1, 1, 3), 104, "R1 divider code 3");
    run(ctl(1, 1, 1, 1, 7), 1664, "R1 divider code 7");
    run(ctl(1, 1, 1, 1, 0), 26, "R1 divider code 0");

    wr(2'd1, 8'b11_0_00_010);
    peek(2'd2, d);
    check(d[15:10] == 6'd0, "R6 right alignment", d[15:10], 0);
    wr(2'd0, ctl(1, 1, 1, 1, 3));
    repeat (10) @(negedge clk);
    wr(2'd0, ctl(0, 0, 0, 1, 3));
    check(busy == 1'b0, "R4 abort stops conversion", busy, 0);
    peek(2'd0, v);
    check(v[4] == 1'b0, "R4 no flag after abort", v[4], 0);
    peek(2'd2, v);
    check(v == d, "R4 result kept after abort", v, d);

    run(ctl(1, 1, 1, 1, 0), 50, "R2 long again after re-enable");
    wr(2'd0, ctl(0, 0, 1, 1, 0));
    wr(2'd0, ctl(1, 0, 0, 1, 0));
    repeat (5) @(negedge clk);
    run(ctl(1, 1, 0, 1, 0), 50, "R2 first start after separate enable");
    run(ctl(1, 1, 0, 1, 0), 26, "R1 following conversion is normal");

    wr(2'd1, 8'b10_0_00_110);
    check(ref_sel == 2'd3 && chan_sel == 3'd6, "R7 reserved reference ignored", ref_sel, 3);

    wr(2'd0, ctl(1, 0, 0, 0, 0));
    check(irq == 1'b0, "R9 irq masked", irq, 0);
    wr(2'd0, ctl(1, 0, 0, 1, 0));
    check(irq == 1'b1, "R9 irq unmasked with flag", irq, 1);

    repeat (3) @(negedge clk);
    ended = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule